// File: doc/BRIEF.md
# Dual-Channel PWM Counter Slice

This block is a single pulse-width modulation slice. A counter advances on each tick supplied by an external rate divider and is compared against two independent compare levels, producing two output waveforms. The counter either climbs to a programmable ceiling and restarts from zero (trailing-edge mode), or climbs to the ceiling and then descends back to zero (phase-correct mode, half the output frequency).

The ceiling and both compare levels are held in shadow registers. While the slice runs, new values take effect only at the end of a period. While it is stopped, they load at once. A control port can overwrite the counter, or request a one-count phase shift in either direction. The slice also emits a one-cycle pulse at each period boundary, which the surrounding logic uses to raise an interrupt and pace DMA transfers.

Top module: `pwm_slice`

## Requirements
- R1: After reset the count is 0, both outputs are low, no phase shift is pending, the compare levels are 0 and the ceiling is all ones (2^CW-1). With ticks running, the count therefore reaches 2^CW-1 before it returns to 0.
- R2: In trailing-edge mode (`phase_correct`=0), each tick while enabled raises the count by one. A tick taken at the ceiling returns the count to 0.
- R3: In phase-correct mode (`phase_correct`=1), the count rises to the ceiling and then falls by one per tick until it reaches 0, after which it rises again.
- R4: Each raw output is 1 when the count is below its compare level and 0 otherwise. The raw output is updated on every count step. A compare level of 0 keeps the output low. A compare level of 1 with a ceiling of 0 keeps it high.
- R5: `wrap_pulse` is high for one cycle together with the count becoming 0 at a period end: in trailing-edge mode on the step after the ceiling, and in phase-correct mode on arrival at 0 while counting down.
- R6: While enabled, a written ceiling or compare level takes effect only at the next period end (the step flagged by `wrap_pulse`).
- R7: While disabled, a written ceiling or compare level takes effect immediately.
- R8: While disabled, ticks are ignored, and the count and the outputs hold. After re-enabling, counting resumes from the held count.
- R9: `adv_req` sets `adv_busy`. On the first later cycle without an enabled tick, the count takes one extra step, the outputs update, and `adv_busy` clears. This also works while the slice is disabled.
- R10: `ret_req` sets `ret_busy`. The next enabled tick is swallowed, so the count does not move, and `ret_busy` clears. Later ticks count normally.
- R11: `inv_a` and `inv_b` invert outputs A and B respectively, and take effect at once.
- R12: A counter write (`ctr_wr`) loads `ctr_wdata` at the next edge and takes priority over a tick in the same cycle. That cycle produces no wrap pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Slice enable |
| tick | input | 1 | Count-enable tick from the divider |
| phase_correct | input | 1 | 1 selects up/down counting |
| inv_a | input | 1 | Invert output A |
| inv_b | input | 1 | Invert output B |
| top_wr | input | 1 | Write strobe for the ceiling |
| top_wdata | input | CW | New ceiling |
| cmp_a_wr | input | 1 | Write strobe for compare A |
| cmp_a_wdata | input | CW | New compare A level |
| cmp_b_wr | input | 1 | Write strobe for compare B |
| cmp_b_wdata | input | CW | New compare B level |
| ctr_wr | input | 1 | Counter write strobe |
| ctr_wdata | input | CW | Counter write value |
| adv_req | input | 1 | Request a one-count advance |
| ret_req | input | 1 | Request a one-count retard |
| count | output | CW | Current count |
| out_a | output | 1 | Output A |
| out_b | output | 1 | Output B |
| wrap_pulse | output | 1 | One-cycle period-end pulse |
| adv_busy | output | 1 | Advance pending |
| ret_busy | output | 1 | Retard pending |

## Verification
The bench builds the slice with CW=8. This narrow counter keeps the all-ones reset ceiling cheap to reach, so a full 256-step period after reset is observed directly rather than assumed. Small programmed ceilings (0, 2, 3, 4) then bring every turnaround into a few cycles: the trailing-edge restart, the phase-correct bounce at both ends, and the degenerate zero ceiling. At those turnarounds the shadow loads, phase shifts and counter overwrites each land at a known count.

// File: rtl/pwm_slice.sv
module pwm_slice #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          phase_correct,
  input  logic          inv_a,
  input  logic          inv_b,
  input  logic          top_wr,
  input  logic [CW-1:0] top_wdata,
  input  logic          cmp_a_wr,
  input  logic [CW-1:0] cmp_a_wdata,
  input  logic          cmp_b_wr,
  input  logic [CW-1:0] cmp_b_wdata,
  input  logic          ctr_wr,
  input  logic [CW-1:0] ctr_wdata,
  input  logic          adv_req,
  input  logic          ret_req,
  output logic [CW-1:0] count,
  output logic          out_a,
  output logic          out_b,
  output logic          wrap_pulse,
  output logic          adv_busy,
  output logic          ret_busy
);

  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] ctr, top_act, top_sh, ca_act, ca_sh, cb_act, cb_sh;
  logic [CW-1:0] nxt, top_sh_n, ca_sh_n, cb_sh_n, top_n, ca_n, cb_n;
  logic          down, nxt_down, at_end;
  logic          raw_a, raw_b, adv_pend, ret_pend, wrap_q;

  wire live     = en & tick;
  wire adv_done = adv_pend & ~live & ~ctr_wr;
  wire ret_done = ret_pend & live & ~ctr_wr;
  wire step     = ~ctr_wr & ((live & ~ret_pend) | (adv_pend & ~live));
  wire wrap     = step & at_end;
  wire load     = ~en | wrap;

  assign top_sh_n = top_wr   ? top_wdata   : top_sh;
  assign ca_sh_n  = cmp_a_wr ? cmp_a_wdata : ca_sh;
  assign cb_sh_n  = cmp_b_wr ? cmp_b_wdata : cb_sh;
  assign top_n    = load ? top_sh_n : top_act;
  assign ca_n     = load ? ca_sh_n  : ca_act;
  assign cb_n     = load ? cb_sh_n  : cb_act;

  always_comb begin
    nxt      = ctr;
    nxt_down = down;
    at_end   = 1'b0;
    if (!phase_correct) begin
      nxt_down = 1'b0;
      if (ctr >= top_act) begin
        nxt    = ZERO;
        at_end = 1'b1;
      end else begin
        nxt = ctr + ONE;
      end
    end else if (!down && ctr < top_act) begin
      nxt = ctr + ONE;
    end else begin
      nxt = (ctr == ZERO) ? ZERO : ctr - ONE;
      if (nxt == ZERO) begin
        at_end   = 1'b1;
        nxt_down = 1'b0;
      end else begin
        nxt_down = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr      <= ZERO;
      down     <= 1'b0;
      top_sh   <= '1;
      top_act  <= '1;
      ca_sh    <= ZERO;
      ca_act   <= ZERO;
      cb_sh    <= ZERO;
      cb_act   <= ZERO;
      raw_a    <= 1'b0;
      raw_b    <= 1'b0;
      adv_pend <= 1'b0;
      ret_pend <= 1'b0;
      wrap_q   <= 1'b0;
    end else begin
      top_sh   <= top_sh_n;
      ca_sh    <= ca_sh_n;
      cb_sh    <= cb_sh_n;
      top_act  <= top_n;
      ca_act   <= ca_n;
      cb_act   <= cb_n;
      adv_pend <= (adv_pend & ~adv_done) | adv_req;
      ret_pend <= (ret_pend & ~ret_done) | ret_req;
      wrap_q   <= wrap;
      if (ctr_wr) begin
        ctr <= ctr_wdata;
      end else if (step) begin
        ctr   <= nxt;
        down  <= nxt_down;
        raw_a <= nxt < ca_n;
        raw_b <= nxt < cb_n;
      end
    end
  end

  assign count      = ctr;
  assign out_a      = raw_a ^ inv_a;
  assign out_b      = raw_b ^ inv_b;
  assign wrap_pulse = wrap_q;
  assign adv_busy   = adv_pend;
  assign ret_busy   = ret_pend;

  assert_trail_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !phase_correct && ctr < top_act) |=> ctr == ($past(ctr) + ONE));

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> count == ZERO);

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !adv_pend && !ctr_wr) |=> (ctr == $past(ctr)) && (raw_a == $past(raw_a)) && (raw_b == $past(raw_b)));

  assert_retard_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ret_pend && !ctr_wr) |=> ctr == $past(ctr));

  assert_ctr_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_wr |=> (ctr == $past(ctr_wdata)) && !wrap_pulse);

endmodule

// File: tb/pwm_slice_tb.sv
module pwm_slice_tb;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, tick = 0, phase_correct = 0, inv_a = 0, inv_b = 0;
  logic top_wr = 0, cmp_a_wr = 0, cmp_b_wr = 0, ctr_wr = 0, adv_req = 0, ret_req = 0;
  logic [CW-1:0] top_wdata = '0, cmp_a_wdata = '0, cmp_b_wdata = '0, ctr_wdata = '0;
  logic [CW-1:0] count;
  logic out_a, out_b, wrap_pulse, adv_busy, ret_busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwm_slice #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .phase_correct(phase_correct),
    .inv_a(inv_a), .inv_b(inv_b),
    .top_wr(top_wr), .top_wdata(top_wdata),
    .cmp_a_wr(cmp_a_wr), .cmp_a_wdata(cmp_a_wdata),
    .cmp_b_wr(cmp_b_wr), .cmp_b_wdata(cmp_b_wdata),
    .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata),
    .adv_req(adv_req), .ret_req(ret_req),
    .count(count), .out_a(out_a), .out_b(out_b), .wrap_pulse(wrap_pulse),
    .adv_busy(adv_busy), .ret_busy(ret_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input int t, input int ca, input int cb, input int c);
    en = 0; tick = 0;
    top_wr = 1; top_wdata = CW'(t);
    cmp_a_wr = 1; cmp_a_wdata = CW'(ca);
    cmp_b_wr = 1; cmp_b_wdata = CW'(cb);
    ctr_wr = 1; ctr_wdata = CW'(c);
    cycle();
    top_wr = 0; cmp_a_wr = 0; cmp_b_wr = 0; ctr_wr = 0;
  endtask

  task automatic test_reset();
    chk("R1 count", int'(count), 0);
    chk("R1 out_a", int'(out_a), 0);
    chk("R1 out_b", int'(out_b), 0);
    chk("R1 adv_busy", int'(adv_busy), 0);
    chk("R1 ret_busy", int'(ret_busy), 0);
    en = 1; tick = 1;
    repeat (255) cycle();
    chk("R1 count at all-ones ceiling", int'(count), 255);
    chk("R5 no wrap before ceiling", int'(wrap_pulse), 0);
    chk("R4 compare 0 keeps A low", int'(out_a), 0);
    cycle();
    chk("R1 count restarts", int'(count), 0);
    chk("R5 wrap at restart", int'(wrap_pulse), 1);
    en = 0; tick = 0;
  endtask

  task automatic test_trailing();
    cfg(4, 2, 0, 0);
    en = 1; tick = 1;
    for (int i = 1; i <= 10; i++) begin
      int c;
      cycle();
      c = i % 5;
      chk("R2 trailing count", int'(count), c);
      chk("R4 out_a vs compare", int'(out_a), (c < 2) ? 1 : 0);
      chk("R4 out_b compare 0", int'(out_b), 0);
      chk("R5 trailing wrap", int'(wrap_pulse), (c == 0) ? 1 : 0);
    end
    en = 0; tick = 0;
  endtask

  task automatic test_phase_correct();
    int seq [8] = '{1, 2, 3, 2, 1, 0, 1, 2};
    phase_correct = 1;
    cfg(3, 2, 3, 0);
    en = 1; tick = 1;
    for (int i = 0; i < 8; i++) begin
      cycle();
      chk("R3 updown count", int'(count), seq[i]);
      chk("R4 pc out_a", int'(out_a), (seq[i] < 2) ? 1 : 0);
      chk("R4 pc out_b", int'(out_b), (seq[i] < 3) ? 1 : 0);
      chk("R5 pc wrap at zero", int'(wrap_pulse), (seq[i] == 0) ? 1 : 0);
    end
    en = 0; tick = 0;
    phase_correct = 0;
  endtask

  task automatic test_double_buffer();
    cfg(4, 2, 0, 0);
    en = 1; tick = 1;
    cycle();
    cmp_a_wr = 1; cmp_a_wdata = 8'd4;
    top_wr = 1; top_wdata = 8'd2;
    cycle();
    cmp_a_wr = 0; top_wr = 0;
    chk("R6 count", int'(count), 2);
    chk("R6 old compare in force", int'(out_a), 0);
    cycle();
    chk("R6 old ceiling in force", int'(count), 3);
    cycle();
    cycle();
    chk("R6 wrap under old ceiling", int'(wrap_pulse), 1);
    chk("R6 new compare after wrap", int'(out_a), 1);
    cycle();
    cycle();
    chk("R6 new compare at 2", int'(out_a), 1);
    cycle();
    chk("R6 new ceiling wraps", int'(count), 0);
    chk("R6 wrap under new ceiling", int'(wrap_pulse), 1);
  endtask

  task automatic test_disabled();
    en = 0;
    cycle();
    cycle();
    chk("R8 frozen count", int'(count), 0);
    chk("R8 held output", int'(out_a), 1);
    cmp_a_wr = 1; cmp_a_wdata = 8'd0;
    adv_req = 1;
    cycle();
    cmp_a_wr = 0; adv_req = 0;
    chk("R9 adv_busy set", int'(adv_busy), 1);
    chk("R8 still frozen", int'(count), 0);
    cycle();
    chk("R9 advance while disabled", int'(count), 1);
    chk("R9 adv_busy clears", int'(adv_busy), 0);
    chk("R7 immediate compare load", int'(out_a), 0);
    en = 1;
    cycle();
    chk("R8 resume", int'(count), 2);
    cycle();
    chk("R8 resume wrap", int'(count), 0);
  endtask

  task automatic test_retard();
    tick = 0;
    ret_req = 1;
    cycle();
    ret_req = 0;
    chk("R10 ret_busy set", int'(ret_busy), 1);
    cycle();
    chk("R10 waits for tick", int'(ret_busy), 1);
    tick = 1;
    cycle();
    tick = 0;
    chk("R10 tick swallowed", int'(count), 0);
    chk("R10 ret_busy clears", int'(ret_busy), 0);
    tick = 1;
    cycle();
    tick = 0;
    chk("R10 next tick counts", int'(count), 1);
    adv_req = 1;
    cycle();
    adv_req = 0;
    cycle();
    chk("R9 advance while enabled", int'(count), 2);
  endtask

  task automatic test_ctr_write();
    tick = 1;
    ctr_wr = 1; ctr_wdata = 8'd1;
    cycle();
    ctr_wr = 0; tick = 0; en = 0;
    chk("R12 write beats tick", int'(count), 1);
    chk("R12 no wrap on write", int'(wrap_pulse), 0);
  endtask

  task automatic test_invert();
    inv_a = 1;
    #1;
    chk("R11 invert A", int'(out_a), 1);
    chk("R11 B untouched", int'(out_b), 0);
    inv_b = 1;
    #1;
    chk("R11 invert B", int'(out_b), 1);
    inv_a = 0; inv_b = 0;
    #1;
    chk("R11 A restored", int'(out_a), 0);
  endtask

  task automatic test_top_zero();
    cfg(0, 1, 0, 0);
    en = 1; tick = 1;
    for (int i = 0; i < 3; i++) begin
      cycle();
      chk("R4 ceiling 0 count", int'(count), 0);
      chk("R4 compare 1 ceiling 0 high", int'(out_a), 1);
      chk("R4 compare 0 low", int'(out_b), 0);
      chk("R5 wrap each step", int'(wrap_pulse), 1);
    end
    en = 0; tick = 0;
    cycle();
    chk("R5 pulse drops", int'(wrap_pulse), 0);
  endtask

  initial begin
    #160000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_trailing();
    test_phase_correct();
    test_double_buffer();
    test_disabled();
    test_retard();
    test_ctr_write();
    test_invert();
    test_top_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule